// File: doc/BRIEF.md
# Backscatter Packet Receiver

This block recovers packets from the low-rate message stream that a power receiver impresses on the coil of an inductive charging transmitter. It takes the comparator output that the analog front end derives from the coil voltage, already synchronised to the clock. It measures the time between successive transitions and turns each interval into a half-bit, a full bit or a reject. Pairs of half-bits become ones and single full intervals become zeros, in a differential bi-phase code that carries 2 kbit/s on a 108 kHz carrier.

A state machine turns the bit stream into framed bytes. Each byte is sent as a start bit, eight data bits, a parity bit and a stop bit. Bytes are grouped into packets: a run of ones, a header byte, the data bytes it announces, then a checksum byte. A complete packet is presented with a one-cycle strobe, together with its header, its data, its length and a checksum flag. Parity and framing faults are reported as one-cycle pulses, and the packet that caused them is dropped.

The framer has five states. HUNT counts consecutive one bits and leaves on a zero bit (the header start bit) once the count has reached the preamble minimum. DATA shifts in eight bits and then moves to PAR. PAR moves to STOP when parity is good and goes back to HUNT when it is not. STOP goes back to HUNT on a zero bit, back to HUNT with a packet strobe after the checksum byte, and otherwise moves to START. START returns to DATA on a zero bit and to HUNT on a one bit. A bit-level abort, caused by a rejected interval or an expired receive time, sends every state back to HUNT.

Top module: `bsr_rx`

## Requirements
- R1: With half period H = HALF_CYC clocks and tolerance T = TOL_CYC clocks, an edge interval of H-T to H+T clocks counts as a half-bit and one of 2H-T to 2H+T clocks counts as a full bit. A full bit decodes as 0 and two consecutive half-bits decode as 1. The first edge after reset or after a timeout only starts the timing.
- R2: An interval outside both windows, or a full interval that follows a single half-bit, discards the partial byte and packet and returns the framer to preamble search without raising any output.
- R3: If no edge arrives within 2H+T clocks of the previous one, the bits received so far are discarded and the framer returns to preamble search. An edge at exactly 2H+T clocks is still accepted as a full bit.
- R4: A packet starts only after at least PRE_MIN (default 11) consecutive one bits followed by a zero, which is the header start bit. A shorter run of ones followed by a zero starts nothing.
- R5: Each byte is a 0 start bit, eight data bits least significant first, a parity bit, then a 1 stop bit.
- R6: Parity is odd over the eight data bits plus the parity bit. A parity error pulses err_parity for one cycle and drops the packet, so pkt_valid does not pulse.
- R7: A 0 in a stop-bit position, or a 1 where the next byte's start bit is due, pulses err_frame for one cycle and drops the packet.
- R8: The number of data bytes is header[LEN_BITS-1:0] + 1 and is given on pkt_len. Data byte i (counted from 0) appears on pkt_data[8i+7:8i], and byte slots beyond the length read zero.
- R9: The byte after the data is the checksum. If it differs from the XOR of the header and all data bytes, pkt_valid pulses with cksum_err = 1; otherwise cksum_err = 0.
- R10: pkt_valid is high for exactly one cycle per packet. pkt_header, pkt_data and pkt_len change only in the cycle pkt_valid is high.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Demodulated comparator output, already synchronised |
| pkt_valid | output | 1 | One-cycle strobe for a completed packet |
| pkt_header | output | 8 | Header byte of the last packet |
| pkt_data | output | 8*2^LEN_BITS | Data bytes of the last packet, byte 0 in the low bits |
| pkt_len | output | LEN_BITS+1 | Number of data bytes of the last packet |
| cksum_err | output | 1 | Checksum mismatch, valid with pkt_valid |
| err_parity | output | 1 | One-cycle pulse on a parity fault |
| err_frame | output | 1 | One-cycle pulse on a stop or start bit fault |

## Verification
The interval classifier and the receive-time limit can act on the same clock. An edge that lands on the last clock of the full-bit window must be treated as a bit, while one clock later the timeout must already have fired. The bench provokes this by stretching the header start bit to exactly 2H+T clocks, which must yield a delivered packet, and then to 2H+T+1 clocks, which must yield no packet and no error pulse. The remaining bits are still sent after the stretched one, so any leftover byte state would show up as a spurious strobe or error.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int BYTE_W = 8;

    // classification of one edge-to-edge interval
    typedef enum logic [1:0] {
        SYM_HALF = 2'd0,
        SYM_FULL = 2'd1,
        SYM_BAD  = 2'd2
    } sym_e;

    // byte/packet framer states
    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_DATA  = 3'd1,
        ST_PAR   = 3'd2,
        ST_STOP  = 3'd3,
        ST_START = 3'd4
    } fr_state_e;

endpackage

// File: rtl/bsr_edge_timer.sv
module bsr_edge_timer
    import bsr_pkg::*;
#(
    parameter int HALF_CYC = 50000,
    parameter int TOL_CYC  = HALF_CYC / 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic sym_valid,
    output sym_e sym_kind,
    output logic tmo
);

    localparam int HALF_MIN = HALF_CYC - TOL_CYC;
    localparam int HALF_MAX = HALF_CYC + TOL_CYC;
    localparam int FULL_MIN = 2 * HALF_CYC - TOL_CYC;
    localparam int FULL_MAX = 2 * HALF_CYC + TOL_CYC;
    localparam int CW       = $clog2(FULL_MAX + 2) + 1;

    logic          line_q;
    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic          edge_seen;
    sym_e          kind_now;

    assign edge_seen = line_in ^ line_q;

    always_comb begin
        if (int'(cnt_q) >= HALF_MIN && int'(cnt_q) <= HALF_MAX) begin
            kind_now = SYM_HALF;
        end else if (int'(cnt_q) >= FULL_MIN && int'(cnt_q) <= FULL_MAX) begin
            kind_now = SYM_FULL;
        end else begin
            kind_now = SYM_BAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q    <= 1'b0;
            armed_q   <= 1'b0;
            cnt_q     <= '0;
            sym_valid <= 1'b0;
            sym_kind  <= SYM_BAD;
            tmo       <= 1'b0;
        end else begin
            line_q    <= line_in;
            sym_valid <= 1'b0;
            tmo       <= 1'b0;
            if (edge_seen) begin
                cnt_q   <= CW'(1);
                armed_q <= 1'b1;
                if (armed_q) begin
                    sym_valid <= 1'b1;
                    sym_kind  <= kind_now;
                end
            end else if (armed_q) begin
                if (int'(cnt_q) == FULL_MAX) begin
                    tmo     <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bsr_bit_decoder.sv
module bsr_bit_decoder
    import bsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    input  sym_e sym_kind,
    input  logic tmo,
    output logic bit_valid,
    output logic bit_val,
    output logic bit_abort
);

    logic half_pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_pend_q <= 1'b0;
            bit_valid   <= 1'b0;
            bit_val     <= 1'b0;
            bit_abort   <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            bit_abort <= 1'b0;
            if (tmo) begin
                half_pend_q <= 1'b0;
                bit_abort   <= 1'b1;
            end else if (sym_valid) begin
                unique case (sym_kind)
                    SYM_HALF: begin
                        if (half_pend_q) begin
                            bit_valid   <= 1'b1;
                            bit_val     <= 1'b1;
                            half_pend_q <= 1'b0;
                        end else begin
                            half_pend_q <= 1'b1;
                        end
                    end
                    SYM_FULL: begin
                        if (half_pend_q) begin
                            bit_abort   <= 1'b1;
                            half_pend_q <= 1'b0;
                        end else begin
                            bit_valid <= 1'b1;
                            bit_val   <= 1'b0;
                        end
                    end
                    default: begin
                        bit_abort   <= 1'b1;
                        half_pend_q <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/bsr_framer.sv
module bsr_framer
    import bsr_pkg::*;
#(
    parameter int LEN_BITS = 3,
    parameter int PRE_MIN  = 11
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bit_valid,
    input  logic                                 bit_val,
    input  logic                                 bit_abort,
    output logic                                 pkt_valid,
    output logic [BYTE_W-1:0]                    pkt_header,
    output logic [(1<<LEN_BITS)*BYTE_W-1:0]      pkt_data,
    output logic [LEN_BITS:0]                    pkt_len,
    output logic                                 cksum_err,
    output logic                                 err_parity,
    output logic                                 err_frame
);

    localparam int MAX_DATA = 1 << LEN_BITS;
    localparam int LW       = LEN_BITS + 1;
    localparam int BW       = $clog2(MAX_DATA + 3);
    localparam int OW       = $clog2(PRE_MIN + 1);
    localparam int IW       = $clog2(BYTE_W);

    fr_state_e                  st_q, st_d;
    logic [OW-1:0]              ones_q;
    logic [IW-1:0]              bit_idx_q;
    logic [BYTE_W-1:0]          shreg_q;
    logic [BYTE_W-1:0]          hdr_q;
    logic [BYTE_W-1:0]          xor_q;
    logic [LW-1:0]              len_q;
    logic [BW-1:0]              byte_idx_q;
    logic [MAX_DATA*BYTE_W-1:0] buf_q;

    logic pre_ok;
    logic par_ok;
    logic last_byte;

    assign pre_ok    = (ones_q == OW'(PRE_MIN));
    assign par_ok    = ^{shreg_q, bit_val};
    assign last_byte = (byte_idx_q != '0) && (int'(byte_idx_q) == int'(len_q) + 1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_HUNT;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (bit_abort) begin
            st_d = ST_HUNT;
        end else if (bit_valid) begin
            unique case (st_q)
                ST_HUNT:  if (!bit_val && pre_ok) st_d = ST_DATA;
                ST_DATA:  if (bit_idx_q == IW'(BYTE_W - 1)) st_d = ST_PAR;
                ST_PAR:   st_d = par_ok ? ST_STOP : ST_HUNT;
                ST_STOP:  st_d = (!bit_val || last_byte) ? ST_HUNT : ST_START;
                ST_START: st_d = bit_val ? ST_HUNT : ST_DATA;
                default:  st_d = ST_HUNT;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q     <= '0;
            bit_idx_q  <= '0;
            shreg_q    <= '0;
            hdr_q      <= '0;
            xor_q      <= '0;
            len_q      <= '0;
            byte_idx_q <= '0;
            buf_q      <= '0;
            pkt_valid  <= 1'b0;
            pkt_header <= '0;
            pkt_data   <= '0;
            pkt_len    <= '0;
            cksum_err  <= 1'b0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
        end else begin
            pkt_valid  <= 1'b0;
            cksum_err  <= 1'b0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
            if (bit_abort) begin
                ones_q <= '0;
            end else if (bit_valid) begin
                if (st_q != ST_HUNT) begin
                    ones_q <= '0;
                end
                unique case (st_q)
                    ST_HUNT: begin
                        if (bit_val) begin
                            if (!pre_ok) ones_q <= ones_q + 1'b1;
                        end else begin
                            ones_q <= '0;
                            if (pre_ok) begin
                                bit_idx_q  <= '0;
                                byte_idx_q <= '0;
                                xor_q      <= '0;
                                buf_q      <= '0;
                            end
                        end
                    end
                    ST_DATA: begin
                        shreg_q   <= {bit_val, shreg_q[BYTE_W-1:1]};
                        bit_idx_q <= bit_idx_q + 1'b1;
                    end
                    ST_PAR: begin
                        if (!par_ok) err_parity <= 1'b1;
                    end
                    ST_STOP: begin
                        if (!bit_val) begin
                            err_frame <= 1'b1;
                        end else if (last_byte) begin
                            pkt_valid  <= 1'b1;
                            pkt_header <= hdr_q;
                            pkt_data   <= buf_q;
                            pkt_len    <= len_q;
                            cksum_err  <= (xor_q != shreg_q);
                        end else begin
                            byte_idx_q <= byte_idx_q + 1'b1;
                            xor_q      <= xor_q ^ shreg_q;
                            if (byte_idx_q == '0) begin
                                hdr_q <= shreg_q;
                                len_q <= LW'(shreg_q[LEN_BITS-1:0]) + 1'b1;
                            end
                            for (int i = 0; i < MAX_DATA; i++) begin
                                if (int'(byte_idx_q) == i + 1) begin
                                    buf_q[i*BYTE_W +: BYTE_W] <= shreg_q;
                                end
                            end
                        end
                    end
                    ST_START: begin
                        if (bit_val) begin
                            err_frame <= 1'b1;
                        end else begin
                            bit_idx_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/bsr_rx.sv
module bsr_rx
    import bsr_pkg::*;
#(
    parameter int HALF_CYC = 50000,
    parameter int TOL_CYC  = HALF_CYC / 4,
    parameter int LEN_BITS = 3,
    parameter int PRE_MIN  = 11
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 line_in,
    output logic                                 pkt_valid,
    output logic [7:0]                           pkt_header,
    output logic [(1<<LEN_BITS)*8-1:0]           pkt_data,
    output logic [LEN_BITS:0]                    pkt_len,
    output logic                                 cksum_err,
    output logic                                 err_parity,
    output logic                                 err_frame
);

    logic sym_valid;
    sym_e sym_kind;
    logic tmo;
    logic bit_valid;
    logic bit_val;
    logic bit_abort;

    bsr_edge_timer #(
        .HALF_CYC (HALF_CYC),
        .TOL_CYC  (TOL_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .sym_valid (sym_valid),
        .sym_kind  (sym_kind),
        .tmo       (tmo)
    );

    bsr_bit_decoder u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_kind  (sym_kind),
        .tmo       (tmo),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .bit_abort (bit_abort)
    );

    bsr_framer #(
        .LEN_BITS (LEN_BITS),
        .PRE_MIN  (PRE_MIN)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .bit_val    (bit_val),
        .bit_abort  (bit_abort),
        .pkt_valid  (pkt_valid),
        .pkt_header (pkt_header),
        .pkt_data   (pkt_data),
        .pkt_len    (pkt_len),
        .cksum_err  (cksum_err),
        .err_parity (err_parity),
        .err_frame  (err_frame)
    );

endmodule

// File: rtl/bsr_rx_chk.sv
module bsr_rx_chk #(
    parameter int LEN_BITS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pkt_valid,
    input logic [7:0]          pkt_header,
    input logic [LEN_BITS:0]   pkt_len,
    input logic                cksum_err,
    input logic                err_parity,
    input logic                err_frame
);

    localparam int MAX_DATA = 1 << LEN_BITS;

    // R10: strobe lasts a single cycle
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);

    // R10: delivered fields hold between strobes
    a_r10_header_held: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> ($stable(pkt_header) && $stable(pkt_len)));

    // R9: checksum flag only accompanies a delivered packet
    a_r9_cksum_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cksum_err |-> pkt_valid);

    // R6: a parity fault never coincides with a delivery
    a_r6_parity_drops: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |-> !pkt_valid);

    // R7: a framing fault never coincides with another outcome
    a_r7_frame_alone: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |-> (!pkt_valid && !err_parity));

    // R8: delivered length lies inside the announced range
    a_r8_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (int'(pkt_len) >= 1 && int'(pkt_len) <= MAX_DATA));

endmodule

bind bsr_rx bsr_rx_chk #(.LEN_BITS(LEN_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_valid  (pkt_valid),
    .pkt_header (pkt_header),
    .pkt_len    (pkt_len),
    .cksum_err  (cksum_err),
    .err_parity (err_parity),
    .err_frame  (err_frame)
);

// File: tb/tb_bsr_rx.sv
`timescale 1ns/1ps
module tb_bsr_rx;

    localparam int H    = 10;
    localparam int T    = 2;
    localparam int LB   = 3;
    localparam int MAXD = 1 << LB;
    localparam int PRE  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b0;

    logic              pkt_valid;
    logic [7:0]        pkt_header;
    logic [MAXD*8-1:0] pkt_data;
    logic [LB:0]       pkt_len;
    logic              cksum_err;
    logic              err_parity;
    logic              err_frame;

    always #2.5 clk = ~clk;

    bsr_rx #(.HALF_CYC(H), .TOL_CYC(T), .LEN_BITS(LB), .PRE_MIN(11)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line),
        .pkt_valid  (pkt_valid),
        .pkt_header (pkt_header),
        .pkt_data   (pkt_data),
        .pkt_len    (pkt_len),
        .cksum_err  (cksum_err),
        .err_parity (err_parity),
        .err_frame  (err_frame)
    );

    int n_chk = 0;
    int n_err = 0;
    int n_pkt = 0;
    int n_perr = 0;
    int n_ferr = 0;
    logic [7:0]        m_hdr = '0;
    logic [MAXD*8-1:0] m_data = '0;
    logic [LB:0]       m_len = '0;
    logic              m_ck = 1'b0;

    // observe outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_valid) begin
                n_pkt  = n_pkt + 1;
                m_hdr  = pkt_header;
                m_data = pkt_data;
                m_len  = pkt_len;
                m_ck   = cksum_err;
            end
            if (err_parity) n_perr = n_perr + 1;
            if (err_frame)  n_ferr = n_ferr + 1;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic stream [0:255];
    int   nbits = 0;
    int   jmode = 0;

    function automatic int jit();
        if (jmode == 1) return T;
        if (jmode == 2) return -T;
        return int'($urandom_range(2)) - 1;
    endfunction

    task automatic hold(input int n);
        line = ~line;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        if (b) begin
            hold(H + jit());
            hold(H + jit());
        end else begin
            hold(2 * H + jit());
        end
    endtask

    task automatic push(input logic b);
        stream[nbits] = b;
        nbits++;
    endtask

    function automatic logic [MAXD*8-1:0] mask_data(input logic [7:0] hdr, input logic [MAXD*8-1:0] d);
        logic [MAXD*8-1:0] r;
        r = '0;
        for (int i = 0; i < MAXD; i++) begin
            if (i < int'(hdr[LB-1:0]) + 1) r[i*8 +: 8] = d[i*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [7:0] xsum(input logic [7:0] hdr, input logic [MAXD*8-1:0] d);
        logic [7:0] x;
        x = hdr;
        for (int i = 0; i < MAXD; i++) x = x ^ d[i*8 +: 8];
        return x;
    endfunction

    // bytes: 0 header, 1..n data, n+1 checksum
    task automatic build(input logic [7:0] hdr, input logic [MAXD*8-1:0] d, input int pre,
                         input int par_flip_k, input int stop0_k, input int nostart_k,
                         input logic [7:0] ck_flip);
        int n;
        logic [7:0] b;
        nbits = 0;
        n = int'(hdr[LB-1:0]) + 1;
        for (int i = 0; i < pre; i++) push(1'b1);
        for (int k = 0; k <= n + 1; k++) begin
            if (k == 0) b = hdr;
            else if (k <= n) b = d[(k-1)*8 +: 8];
            else b = xsum(hdr, d) ^ ck_flip;
            push(k == nostart_k);
            for (int j = 0; j < 8; j++) push(b[j]);
            push(~(^b) ^ (k == par_flip_k));
            push(k != stop0_k);
        end
    endtask

    task automatic send(input int gap_at, input int gap_len, input int bad_at);
        for (int i = 0; i < nbits; i++) begin
            if (i == gap_at) begin
                hold(gap_len);
            end else if (i == bad_at) begin
                hold(15);
                hold(5);
            end else begin
                send_bit(stream[i]);
            end
        end
        hold(60);
    endtask

    task automatic good_packet(input string req, input logic [7:0] hdr, input logic [MAXD*8-1:0] raw,
                               input int pre, input int gap_at, input int gap_len);
        logic [MAXD*8-1:0] d;
        int p0, e0, f0;
        d  = mask_data(hdr, raw);
        p0 = n_pkt; e0 = n_perr; f0 = n_ferr;
        build(hdr, d, pre, -1, -1, -1, 8'h00);
        send(gap_at, gap_len, -1);
        chk(req, "packet count", n_pkt, p0 + 1);
        chk("R5", "header", m_hdr, hdr);
        chk("R8", "length", m_len, int'(hdr[LB-1:0]) + 1);
        chk("R8", "data", m_data, d);
        chk("R9", "checksum flag clear", m_ck, 0);
        chk("R6", "no parity pulse", n_perr, e0);
        chk("R7", "no frame pulse", n_ferr, f0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R3 watchdog: actual run still busy expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] hdr;
        logic [MAXD*8-1:0] d;
        int p0, e0, f0;
        void'($urandom(32'h5EED_2024));
        repeat (5) @(negedge clk);
        // R11: reset state
        chk("R11", "pkt_valid in reset", pkt_valid, 0);
        chk("R11", "header in reset", pkt_header, 0);
        chk("R11", "data in reset", pkt_data, 0);
        chk("R11", "len in reset", pkt_len, 0);
        chk("R11", "flags in reset", {cksum_err, err_parity, err_frame}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "outputs after reset", {pkt_valid, cksum_err, err_parity, err_frame}, 0);

        // R1 R4 R5 R8: random packets with jitter
        for (int r = 0; r < 6; r++) begin
            good_packet("R1", 8'($urandom), {$urandom, $urandom}, PRE, -1, 0);
        end
        // R8: longest and shortest lengths
        good_packet("R8", 8'hA7, {$urandom, $urandom}, PRE, -1, 0);
        good_packet("R8", 8'h50, {$urandom, $urandom}, PRE, -1, 0);
        // R1: window edges, wide then narrow intervals
        jmode = 1;
        good_packet("R1", 8'h3B, {$urandom, $urandom}, PRE, -1, 0);
        jmode = 2;
        good_packet("R1", 8'hC2, {$urandom, $urandom}, PRE, -1, 0);
        jmode = 0;

        // R9: corrupted checksum
        hdr = 8'h64;
        d = mask_data(hdr, {$urandom, $urandom});
        p0 = n_pkt;
        build(hdr, d, PRE, -1, -1, -1, 8'h10);
        send(-1, 0, -1);
        chk("R9", "delivered despite bad checksum", n_pkt, p0 + 1);
        chk("R9", "checksum flag set", m_ck, 1);
        chk("R9", "header with bad checksum", m_hdr, hdr);

        // R6: parity fault in the second data byte
        hdr = 8'h13;
        d = mask_data(hdr, {$urandom, $urandom});
        p0 = n_pkt; e0 = n_perr;
        build(hdr, d, PRE, 2, -1, -1, 8'h00);
        send(-1, 0, -1);
        chk("R6", "parity pulse", n_perr, e0 + 1);
        chk("R6", "packet dropped", n_pkt, p0);

        // R7: zero stop bit in the header
        p0 = n_pkt; f0 = n_ferr;
        build(hdr, d, PRE, -1, 0, -1, 8'h00);
        send(-1, 0, -1);
        chk("R7", "frame pulse on stop", n_ferr, f0 + 1);
        chk("R7", "packet dropped on stop", n_pkt, p0);

        // R7: missing start bit of the first data byte
        p0 = n_pkt; f0 = n_ferr;
        build(hdr, d, PRE, -1, -1, 1, 8'h00);
        send(-1, 0, -1);
        chk("R7", "frame pulse on start", n_ferr, f0 + 1);
        chk("R7", "packet dropped on start", n_pkt, p0);

        // R4: ten ones is too short, eleven is enough
        p0 = n_pkt; e0 = n_perr; f0 = n_ferr;
        build(8'h21, mask_data(8'h21, {$urandom, $urandom}), 10, -1, -1, -1, 8'h00);
        send(-1, 0, -1);
        chk("R4", "short preamble ignored", n_pkt, p0);
        chk("R4", "short preamble no pulses", n_perr + n_ferr, e0 + f0);
        good_packet("R4", 8'h21, {$urandom, $urandom}, 11, -1, 0);

        // R3: start bit stretched to the last accepted clock, then one past it
        good_packet("R3", 8'h45, {$urandom, $urandom}, PRE, PRE, 2 * H + T);
        p0 = n_pkt; e0 = n_perr; f0 = n_ferr;
        build(8'h45, mask_data(8'h45, {$urandom, $urandom}), PRE, -1, -1, -1, 8'h00);
        send(PRE, 2 * H + T + 1, -1);
        chk("R3", "timeout drops packet", n_pkt, p0);
        chk("R3", "timeout raises nothing", n_perr + n_ferr, e0 + f0);

        // R2: interval between the windows inside the header
        p0 = n_pkt; e0 = n_perr; f0 = n_ferr;
        build(8'h92, mask_data(8'h92, {$urandom, $urandom}), PRE, -1, -1, -1, 8'h00);
        send(-1, 0, PRE + 3);
        chk("R2", "bad interval drops packet", n_pkt, p0);
        chk("R2", "bad interval raises nothing", n_perr + n_ferr, e0 + f0);
        good_packet("R2", 8'h92, {$urandom, $urandom}, PRE, -1, 0);

        finish_run();
    end

endmodule